// File: doc/BRIEF.md
# Single-Precision Result Packer

This block turns an unpacked floating-point result into a 32-bit IEEE-754 single-precision word. Each cycle it takes a sign, a class code, an unbiased exponent, a 26-bit mantissa and a sticky bit. The mantissa holds an explicit leading one at bit 25, 23 fraction bits at 24..2, the guard bit at bit 1 and the round bit at bit 0. The block also takes a 2-bit rounding mode and an underflow-trap-enable bit.

For finite numbers the block biases the exponent. When the biased exponent is zero or negative, the block shifts the mantissa down into the subnormal range. It then rounds with the selected mode, follows a rounding carry into the next binade, and resolves overflow to infinity or to the largest finite value depending on the mode. Zero, infinity and NaN inputs bypass this arithmetic.

The packed word and three flags (inexact, underflow, overflow) appear one clock after the inputs are presented. A new input can be accepted every cycle.

Top module: `spf_pack`

## Requirements
- R1: All outputs are registered and appear on the clock edge after the inputs are sampled. While rst_ni is low, word_o and all flags are zero.
- R2: A class code of 0 (zero) or any unused code (5, 6, 7) outputs only the sign in bit 31, with every other bit and every flag cleared.
- R3: Class code 2 (infinity) outputs the sign, exponent field 0xFF and fraction 0. All flags stay clear in every rounding mode.
- R4: Class codes 3 (quiet NaN) and 4 (signalling NaN) output the sign and exponent field 0xFF. The fraction field is mant_i[24:2] with fraction bit 22 forced to 1. All flags stay clear.
- R5: For class code 1 (number), the exponent field is exp_i+127 and the fraction is mant_i[24:2]. When the guard bit, round bit and sticky bit are all zero, no flag is raised.
- R6: The rounding mode encoding is 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. Nearest-even increments when guard is set and (round, sticky or the kept LSB is set). Modes 2 and 3 increment on any nonzero discarded bit, but only for positive and negative values respectively. inexact_o is set whenever any discarded bit (guard, round, sticky, or a bit shifted out) is nonzero.
- R7: If rounding a normal mantissa gives 2.0, the exponent field is one higher and the fraction is zero.
- R8: If exp_i+127 <= 0, the mantissa is shifted right by 1-(exp_i+127) before rounding, with shifted-out bits merged into sticky. The exponent field is then 0.
- R9: If rounding a subnormal carries into the hidden-bit position, the result has exponent field 1 and fraction 0, and underflow_o stays clear.
- R10: For a result that stays subnormal, underflow_o is set when the result is inexact or when uf_trap_i is 1.
- R11: If the final exponent field would be 255 or more, overflow resolves by mode. Mode 0 gives infinity. Mode 1 gives the sign with 0x7F7FFFFF. Mode 2 gives infinity for positive values only. Mode 3 gives infinity for negative values only. overflow_o is set exactly when the result is infinity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the value |
| cls_i | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| exp_i | input | EXP_W (10) | Signed unbiased exponent |
| mant_i | input | 26 | Leading one, 23 fraction bits, guard bit, round bit |
| stk_i | input | 1 | Sticky bit from earlier arithmetic |
| rm_i | input | 2 | Rounding mode |
| uf_trap_i | input | 1 | Underflow trap enabled |
| word_o | output | 32 | Packed single-precision word |
| inexact_o | output | 1 | Result was rounded |
| underflow_o | output | 1 | Subnormal underflow |
| overflow_o | output | 1 | Overflow resolved to infinity |

## Verification
Two functions can be triggered in the same cycle.

The first pair is the rounding carry and overflow detection. A biased exponent of 254 with an all-ones mantissa, under nearest-even, carries into exponent 255. The bench requires infinity with both inexact and overflow set.

The second pair is subnormal denormalisation and rounding promotion. The largest subnormal pattern is driven with uf_trap_i high, and the bench expects the smallest normal with underflow clear, because promotion overrides the trap request. The same pattern under toward-zero mode must stay subnormal with underflow raised.

A behavioural model in the bench computes each result from remainder-versus-half comparisons. The bench compares the outputs every cycle against the model, for both directed and random vectors.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int FRAC_W   = 23;
  localparam int EXPF_W   = 8;
  localparam int MANT_W   = FRAC_W + 3;
  localparam int BIAS     = 127;
  localparam int EXPF_MAX = 255;
  localparam int WORD_W   = 1 + EXPF_W + FRAC_W;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } cls_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rm_e;
endpackage

// File: rtl/spf_align.sv
module spf_align #(
  parameter int MANT_W = 26,
  parameter int SH_W   = 5
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic              stk_i,
  input  logic [SH_W-1:0]   sh_i,
  output logic [MANT_W-3:0] kept_o,
  output logic              grd_o,
  output logic              rnd_o,
  output logic              stk_o
);
  logic [MANT_W-1:0] shifted;
  logic              lost;

  always_comb begin
    shifted = mant_i >> sh_i;
    lost    = 1'b0;
    for (int k = 0; k < MANT_W; k++) begin
      if (k < int'(sh_i)) lost = lost | mant_i[k];
    end
  end

  assign kept_o = shifted[MANT_W-1:2];
  assign grd_o  = shifted[1];
  assign rnd_o  = shifted[0];
  assign stk_o  = stk_i | lost;
endmodule

// File: rtl/spf_round.sv
module spf_round
  import spf_pkg::*;
#(
  parameter int KEEP_W = 24
) (
  input  logic [KEEP_W-1:0] kept_i,
  input  logic              grd_i,
  input  logic              rnd_i,
  input  logic              stk_i,
  input  logic              sign_i,
  input  logic [1:0]        rm_i,
  output logic [KEEP_W:0]   sum_o,
  output logic              inexact_o
);
  logic inc;
  logic any_lost;

  assign any_lost = grd_i | rnd_i | stk_i;

  always_comb begin
    case (rm_e'(rm_i))
      RM_NEAR: inc = grd_i & (rnd_i | stk_i | kept_i[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~sign_i & any_lost;
      default: inc = sign_i & any_lost;
    endcase
  end

  assign sum_o     = {1'b0, kept_i} + (KEEP_W+1)'(inc);
  assign inexact_o = any_lost;
endmodule

// File: rtl/spf_ovf_sel.sv
module spf_ovf_sel
  import spf_pkg::*;
(
  input  logic              sign_i,
  input  logic [1:0]        rm_i,
  output logic              to_inf_o,
  output logic [WORD_W-2:0] mag_o
);
  always_comb begin
    case (rm_e'(rm_i))
      RM_NEAR: to_inf_o = 1'b1;
      RM_ZERO: to_inf_o = 1'b0;
      RM_UP:   to_inf_o = ~sign_i;
      default: to_inf_o = sign_i;
    endcase
  end

  // infinity or largest finite magnitude
  assign mag_o = to_inf_o ? {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}}
                          : {{(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
endmodule

// File: rtl/spf_pack.sv
module spf_pack
  import spf_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sign_i,
  input  logic [2:0]              cls_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic                    stk_i,
  input  logic [1:0]              rm_i,
  input  logic                    uf_trap_i,
  output logic [WORD_W-1:0]       word_o,
  output logic                    inexact_o,
  output logic                    underflow_o,
  output logic                    overflow_o
);
  localparam int BEXP_W = EXP_W + 2;
  localparam int SH_MAX = MANT_W + 1;
  localparam int SH_W   = $clog2(SH_MAX + 1);
  localparam int KEEP_W = FRAC_W + 1;

  logic signed [BEXP_W-1:0] biased, sh_raw, exp_n;
  logic                     subn, carry, promo, ovf_hit;
  logic [SH_W-1:0]          sh;
  logic [KEEP_W-1:0]        kept;
  logic                     grd, rnd, stk;
  logic [KEEP_W:0]          sum;
  logic                     ix;
  logic                     to_inf;
  logic [WORD_W-2:0]        ovf_mag;

  logic [WORD_W-1:0]        word_d;
  logic                     ix_d, uf_d, of_d;

  assign biased = $signed({{2{exp_i[EXP_W-1]}}, exp_i}) + $signed(BEXP_W'(BIAS));
  assign subn   = (biased <= 0);
  assign sh_raw = $signed(BEXP_W'(1)) - biased;

  always_comb begin
    if (!subn)                                   sh = '0;
    else if (sh_raw > $signed(BEXP_W'(SH_MAX)))  sh = SH_W'(SH_MAX);
    else                                         sh = sh_raw[SH_W-1:0];
  end

  spf_align #(.MANT_W(MANT_W), .SH_W(SH_W)) u_align (
    .mant_i (mant_i),
    .stk_i  (stk_i),
    .sh_i   (sh),
    .kept_o (kept),
    .grd_o  (grd),
    .rnd_o  (rnd),
    .stk_o  (stk)
  );

  spf_round #(.KEEP_W(KEEP_W)) u_round (
    .kept_i    (kept),
    .grd_i     (grd),
    .rnd_i     (rnd),
    .stk_i     (stk),
    .sign_i    (sign_i),
    .rm_i      (rm_i),
    .sum_o     (sum),
    .inexact_o (ix)
  );

  spf_ovf_sel u_ovf (
    .sign_i   (sign_i),
    .rm_i     (rm_i),
    .to_inf_o (to_inf),
    .mag_o    (ovf_mag)
  );

  assign carry   = sum[KEEP_W];
  assign promo   = sum[FRAC_W];
  assign exp_n   = biased + $signed({{(BEXP_W-1){1'b0}}, carry});
  assign ovf_hit = !subn && (exp_n >= $signed(BEXP_W'(EXPF_MAX)));

  always_comb begin
    word_d = {sign_i, {(WORD_W-1){1'b0}}};
    ix_d   = 1'b0;
    uf_d   = 1'b0;
    of_d   = 1'b0;
    case (cls_i)
      CLS_INF:  word_d = {sign_i, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
      CLS_QNAN,
      CLS_SNAN: word_d = {sign_i, {EXPF_W{1'b1}}, 1'b1, mant_i[MANT_W-3:2]};
      CLS_NUM: begin
        ix_d = ix;
        if (subn) begin
          if (promo) begin
            word_d = {sign_i, EXPF_W'(1), {FRAC_W{1'b0}}};
          end else begin
            word_d = {sign_i, {EXPF_W{1'b0}}, sum[FRAC_W-1:0]};
            uf_d   = ix | uf_trap_i;
          end
        end else if (ovf_hit) begin
          word_d = {sign_i, ovf_mag};
          of_d   = to_inf;
        end else begin
          // on carry sum[FRAC_W-1:0] is already zero
          word_d = {sign_i, exp_n[EXPF_W-1:0], sum[FRAC_W-1:0]};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o      <= '0;
      inexact_o   <= 1'b0;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      word_o      <= word_d;
      inexact_o   <= ix_d;
      underflow_o <= uf_d;
      overflow_o  <= of_d;
    end
  end

  AST_ZERO_SIGN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i == CLS_ZERO) |=> (word_o == {$past(sign_i), {(WORD_W-1){1'b0}}})); // R2

  AST_NONNUM_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i != CLS_NUM) |=> !(inexact_o || underflow_o || overflow_o)); // R2

  AST_INF_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i == CLS_INF) |=> (word_o[WORD_W-2:0] == {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}})); // R3

  AST_NAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i == CLS_QNAN || cls_i == CLS_SNAN) |=>
      (word_o[WORD_W-2:FRAC_W] == {EXPF_W{1'b1}} && word_o[FRAC_W-1])); // R4

  AST_UF_SUBNORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (word_o[WORD_W-2:FRAC_W] == '0)); // R10

  AST_OVF_IS_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (word_o[WORD_W-2:0] == {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}} && inexact_o == inexact_o
                    && !underflow_o)); // R11

  AST_EXACT_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_i == CLS_NUM && exp_i >= 0 && exp_i < 100 && mant_i[1:0] == 2'b00 && !stk_i)
      |=> !(inexact_o || underflow_o || overflow_o)); // R5
endmodule

// File: tb/tb_spf_pack.sv
`timescale 1ns/1ps
module tb_spf_pack;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sign = 1'b0;
  logic [2:0]        cls = 3'd0;
  logic signed [9:0] expv = '0;
  logic [25:0]       mant = '0;
  logic              stk = 1'b0;
  logic [1:0]        rm = 2'd0;
  logic              uft = 1'b0;
  logic [31:0]       word;
  logic              ix, uf, of;

  int checks = 0;
  int fails  = 0;

  logic        pend = 1'b0;
  logic [34:0] want;
  string       want_tag;

  always #2 clk = ~clk;

  spf_pack dut (
    .clk_i(clk), .rst_ni(rst_n), .sign_i(sign), .cls_i(cls), .exp_i(expv),
    .mant_i(mant), .stk_i(stk), .rm_i(rm), .uf_trap_i(uft),
    .word_o(word), .inexact_o(ix), .underflow_o(uf), .overflow_o(of)
  );

  function automatic logic [34:0] model(input logic s, input logic [2:0] c, input int e,
                                        input logic [25:0] m, input logic st,
                                        input logic [1:0] r, input logic ut);
    int b, sh, eb;
    longint unsigned v, tail, half, kept, sum;
    logic nz, inc, toinf;
    logic [31:0] w;
    case (c)
      3'd2: return {s, 8'hFF, 23'd0, 3'b000};
      3'd3, 3'd4: return {s, 8'hFF, 1'b1, m[23:2], 3'b000};
      3'd1: ;
      default: return {s, 31'd0, 3'b000};
    endcase
    b  = e + 127;
    sh = (b <= 0) ? 1 - b : 0;
    half = 64'd1 << 39;
    if (sh > 30) begin
      kept = 0; tail = 1;
    end else begin
      v    = (64'(m) << 38) >> sh;
      kept = v >> 40;
      tail = v & ((64'd1 << 40) - 1);
    end
    nz = (tail != 0) || st;
    case (r)
      2'd0: inc = (tail > half) || (tail == half && (st || (kept & 1) != 0));
      2'd1: inc = 1'b0;
      2'd2: inc = !s && nz;
      default: inc = s && nz;
    endcase
    sum = kept + 64'(inc);
    if (b <= 0) begin
      if (sum == (64'd1 << 23)) return {s, 8'd1, 23'd0, nz, 1'b0, 1'b0};
      return {s, 8'd0, 23'(sum), nz, nz | ut, 1'b0};
    end
    eb = b + ((sum == (64'd1 << 24)) ? 1 : 0);
    if (eb >= 255) begin
      toinf = (r == 2'd0) || (r == 2'd2 && !s) || (r == 2'd3 && s);
      w = toinf ? {s, 8'hFF, 23'd0} : {s, 8'hFE, 23'h7FFFFF};
      return {w, nz, 1'b0, toinf};
    end
    return {s, 8'(eb), 23'(sum), nz, 1'b0, 1'b0};
  endfunction

  task automatic check_out();
    checks++;
    if ({word, ix, uf, of} !== want) begin
      fails++;
      $display("FAIL %s: got word=%h ix=%b uf=%b of=%b expected word=%h ix=%b uf=%b of=%b",
               want_tag, word, ix, uf, of, want[34:3], want[2], want[1], want[0]);
    end
  endtask

  task automatic step(input logic s, input logic [2:0] c, input int e, input logic [25:0] m,
                      input logic st, input logic [1:0] r, input logic ut, input string tag);
    @(negedge clk);
    if (pend) check_out();
    sign = s; cls = c; expv = 10'(e); mant = m; stk = st; rm = r; uft = ut;
    want = model(s, c, e, m, st, r, ut);
    want_tag = tag;
    pend = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({word, ix, uf, of} !== 35'd0) begin
      fails++;
      $display("FAIL R1 reset: got %h expected 0", {word, ix, uf, of});
    end
    rst_n = 1'b1;

    // R5 plain normals
    step(0, 1, 0,   26'h2000000, 0, 0, 0, "R5 one");
    step(1, 1, 1,   26'h3000000, 0, 0, 0, "R5 neg three");
    step(0, 1, 127, 26'h2000000, 0, 0, 0, "R5 exp 254");
    // R6 rounding modes
    step(0, 1, 0, 26'h2000002, 0, 0, 0, "R6 tie even down");
    step(0, 1, 0, 26'h2000006, 0, 0, 0, "R6 tie odd up");
    step(0, 1, 0, 26'h2000002, 1, 0, 0, "R6 above half via sticky");
    step(0, 1, 0, 26'h2000007, 1, 1, 0, "R6 toward zero");
    step(0, 1, 0, 26'h2000001, 0, 2, 0, "R6 up positive");
    step(1, 1, 0, 26'h2000001, 0, 2, 0, "R6 up negative");
    step(1, 1, 0, 26'h2000000, 1, 3, 0, "R6 down negative");
    step(0, 1, 0, 26'h2000000, 1, 3, 0, "R6 down positive");
    // R7 binade carry
    step(0, 1, 0, 26'h3FFFFFF, 0, 0, 0, "R7 carry to 2.0");
    // R11 overflow, with carry in same cycle
    step(0, 1, 127, 26'h3FFFFFF, 0, 0, 0, "R11 R7 carry overflow");
    step(1, 1, 200, 26'h2000000, 0, 1, 0, "R11 toward zero sat");
    step(0, 1, 128, 26'h2000000, 0, 2, 0, "R11 up positive inf");
    step(1, 1, 128, 26'h2000000, 0, 2, 0, "R11 up negative sat");
    step(1, 1, 128, 26'h2000000, 0, 3, 0, "R11 down negative inf");
    step(0, 1, 128, 26'h2000000, 0, 3, 0, "R11 down positive sat");
    // R8 / R10 subnormals
    step(0, 1, -127, 26'h2000000, 0, 0, 0, "R8 exact subnormal");
    step(0, 1, -127, 26'h2000000, 0, 0, 1, "R10 trap enabled exact");
    step(0, 1, -149, 26'h2000000, 0, 0, 0, "R8 smallest subnormal");
    step(1, 1, -151, 26'h2000000, 0, 0, 0, "R10 rounds to zero");
    step(0, 1, -500, 26'h2000000, 0, 2, 0, "R8 deep shift up");
    step(0, 1, -130, 26'h2000005, 0, 0, 0, "R8 shifted bits to sticky");
    // R9 promotion with trap enabled, then same pattern held down
    step(0, 1, -127, 26'h3FFFFFF, 0, 0, 1, "R9 promote to normal");
    step(0, 1, -127, 26'h3FFFFFF, 0, 1, 1, "R10 stays subnormal");
    // R2 R3 R4 special classes
    step(1, 0, 50, 26'h3FFFFFF, 1, 0, 1, "R2 zero");
    step(0, 5, 10, 26'h2345678, 1, 2, 1, "R2 unused code");
    step(0, 2, 0, 26'h3FFFFFF, 1, 1, 0, "R3 infinity");
    step(1, 2, 0, 26'h0, 0, 3, 0, "R3 neg infinity");
    step(0, 3, 0, 26'h3000004, 1, 0, 0, "R4 quiet nan");
    step(1, 4, 0, 26'h2000008, 0, 0, 1, "R4 signalling nan");

    // random numbers across normal, subnormal and overflow ranges
    for (int i = 0; i < 400; i++) begin
      step(1'($urandom), 3'd1, int'($urandom_range(0, 300)) - 160,
           {1'b1, 25'($urandom)}, 1'($urandom), 2'($urandom), 1'($urandom), "R6 random");
    end
    @(negedge clk);
    if (pend) check_out();
    finish_run();
  end
endmodule